// File: doc/BRIEF.md
# Hardware Reset and Attach Sequencer

This block sequences the bring-up of a hub device after its external active-low reset pin is pulsed. The pin is synchronized and filtered, so a pulse counts only if it stays low long enough. While a valid reset is present, and through a following stabilization wait, the block holds the device core in reset. It then releases the core and opens a bounded window in which an embedded microcontroller writes the configuration registers.

When the firmware reports that configuration is done, the block drives the upstream attach enable. It then waits for the host to signal a bus reset. Once that arrives, the block moves to its operating state. In that state a per-request response timer makes sure each host request is answered in time.

All stage durations are counted on a 1 MHz tick input and set by parameters. Any overrun sends the block into a fault state. The fault state raises a timeout flag and is left only through a new valid pin reset.

Top module: `usb_bringup_seq`

## Requirements
- R1: After `rst_ni` is released while the reset pin is low, `state_o` = 0 (reset stage), `core_rst_o` = 1, and `cfg_en_o`, `attach_o` and `timeout_o` are 0.
- R2: The reset pin is sampled through a two-flop synchronizer. If it stays low for at least `RST_MIN_CYC` clock cycles, the block enters the reset stage (`state_o` = 0) from any state and holds `core_rst_o` = 1 while the pin is low. After the pin goes high, the block moves to the recovery stage (`state_o` = 1).
- R3: The recovery stage keeps `core_rst_o` = 1 for `RECOVER_US` ticks and then enters the configuration stage (`state_o` = 2). A `cfg_done_i` pulse during recovery has no effect.
- R4: In the configuration stage `cfg_en_o` = 1 and `core_rst_o` = 0. If `cfg_done_i` does not arrive within `CFG_MAX_US` ticks, the block enters the fault stage (`state_o` = 5) with `timeout_o` = 1.
- R5: A `cfg_done_i` pulse in the configuration stage moves the block to the attach stage (`state_o` = 3) on the next clock. In that stage `attach_o` = 1 and `cfg_en_o` = 0.
- R6: In the attach stage, `bus_rst_i` moves the block to the operating stage (`state_o` = 4) with `attach_o` still 1. If no bus reset arrives within `ATTACH_MAX_US` ticks, the block enters the fault stage.
- R7: In the operating stage, `req_start_i` arms the response timer and `req_done_i` disarms it. An idle period of any length while the timer is disarmed causes no fault. An armed timer that reaches `RESP_MAX_US` ticks moves the block to the fault stage.
- R8: The fault stage drives `timeout_o` = 1, `attach_o` = 0, `cfg_en_o` = 0 and `core_rst_o` = 1. It ignores every input except a valid pin reset.
- R9: A low pulse on the reset pin shorter than `RST_MIN_CYC` clock cycles has no effect on the state or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| ext_rst_ni | input | 1 | External active-low reset pin, asynchronous |
| tick_i | input | 1 | One-cycle strobe at 1 MHz |
| cfg_done_i | input | 1 | Firmware configuration-done strobe |
| bus_rst_i | input | 1 | Upstream bus reset detected |
| req_start_i | input | 1 | Host request received |
| req_done_i | input | 1 | Request answered |
| core_rst_o | output | 1 | Core reset hold |
| cfg_en_o | output | 1 | Configuration window open |
| attach_o | output | 1 | Upstream attach enable |
| state_o | output | 3 | Stage: 0 reset, 1 recovery, 2 config, 3 attach, 4 operating, 5 fault |
| timeout_o | output | 1 | Timeout fault flag |

## Verification
The bench walks the full stage order several times, each time with a different input pattern. The patterns are a clean bring-up, a configuration strobe sent too early, a firmware that never reports done, a host that never sends a bus reset, and a request that is answered in time next to one that is not. Each stage is sampled both well before and well after its limit, so a stage left too early and a limit never enforced give different results. Reset pin pulses just too short and well long enough are applied in the operating, fault and configuration stages, which shows whether the filter and the return to the reset stage work.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_RECOVER = 3'd1,
    ST_CONFIG  = 3'd2,
    ST_ATTACH  = 3'd3,
    ST_ACTIVE  = 3'd4,
    ST_FAULT   = 3'd5
  } seq_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int unsigned RST_MIN_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic hit_o,
  output logic pin_hi_o
);
  localparam int unsigned FW = $clog2(RST_MIN_CYC + 1);
  localparam logic [FW-1:0] CNT_TOP = FW'(RST_MIN_CYC);

  logic [1:0]    sync_q;
  logic [FW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], pin_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_cnt_q <= '0;
    else if (sync_q[1])         low_cnt_q <= '0;
    else if (low_cnt_q != CNT_TOP) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign hit_o    = (low_cnt_q == CNT_TOP);
  assign pin_hi_o = sync_q[1];

  // a qualified reset requires the synced pin low on the previous cycle too
  assert_hit_needs_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(!sync_q[1]));
endmodule

// File: rtl/rsq_tick_timer.sv
module rsq_tick_timer #(
  parameter int unsigned TW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q >= limit_i);

  assert_timer_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm import rsq_pkg::*; #(
  parameter int unsigned TW            = 17,
  parameter int unsigned RECOVER_US    = 500,
  parameter int unsigned CFG_MAX_US    = 50000,
  parameter int unsigned ATTACH_MAX_US = 100000,
  parameter int unsigned RESP_MAX_US   = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rst_hit_i,
  input  logic          pin_hi_i,
  input  logic          cfg_done_i,
  input  logic          bus_rst_i,
  input  logic          req_start_i,
  input  logic          req_done_i,
  input  logic          expire_i,
  output logic          tmr_clr_o,
  output logic [TW-1:0] limit_o,
  output logic          core_rst_o,
  output logic          cfg_en_o,
  output logic          attach_o,
  output logic [2:0]    state_o,
  output logic          timeout_o
);
  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    if (rst_hit_i) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:   if (pin_hi_i) state_d = ST_RECOVER;
        ST_RECOVER: if (expire_i) state_d = ST_CONFIG;
        ST_CONFIG: begin
          if (cfg_done_i)    state_d = ST_ATTACH;
          else if (expire_i) state_d = ST_FAULT;
        end
        ST_ATTACH: begin
          if (bus_rst_i)     state_d = ST_ACTIVE;
          else if (expire_i) state_d = ST_FAULT;
        end
        ST_ACTIVE:
          if (pend_q && expire_i && !req_done_i && !req_start_i && !bus_rst_i)
            state_d = ST_FAULT;
        ST_FAULT:   state_d = ST_FAULT;
        default:    state_d = ST_RESET;
      endcase
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (req_start_i)                   pend_d = 1'b1;
    else if (req_done_i || bus_rst_i)  pend_d = 1'b0;
    if (state_q != ST_ACTIVE || state_d != ST_ACTIVE) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign tmr_clr_o = (state_d != state_q) || (state_q == ST_ACTIVE && req_start_i);

  always_comb begin
    unique case (state_q)
      ST_RECOVER: limit_o = TW'(RECOVER_US);
      ST_CONFIG:  limit_o = TW'(CFG_MAX_US);
      ST_ATTACH:  limit_o = TW'(ATTACH_MAX_US);
      ST_ACTIVE:  limit_o = TW'(RESP_MAX_US);
      default:    limit_o = '1;
    endcase
  end

  assign core_rst_o = (state_q == ST_RESET) || (state_q == ST_RECOVER) || (state_q == ST_FAULT);
  assign cfg_en_o   = (state_q == ST_CONFIG);
  assign attach_o   = (state_q == ST_ATTACH) || (state_q == ST_ACTIVE);
  assign timeout_o  = (state_q == ST_FAULT);
  assign state_o    = state_q;

  assert_reset_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_hit_i |=> (state_q == ST_RESET));

  assert_recover_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER && !expire_i && !rst_hit_i) |=> (state_q == ST_RECOVER));

  assert_attach_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIG && cfg_done_i && !rst_hit_i) |=> (state_q == ST_ATTACH));

  assert_fault_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT && !rst_hit_i) |=> (state_q == ST_FAULT));

  assert_cfg_timeout_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONFIG && expire_i && !cfg_done_i && !rst_hit_i) |=> timeout_o);
endmodule

// File: rtl/usb_bringup_seq.sv
module usb_bringup_seq import rsq_pkg::*; #(
  parameter int unsigned RST_MIN_CYC   = 50,
  parameter int unsigned RECOVER_US    = 500,
  parameter int unsigned CFG_MAX_US    = 50000,
  parameter int unsigned ATTACH_MAX_US = 100000,
  parameter int unsigned RESP_MAX_US   = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       tick_i,
  input  logic       cfg_done_i,
  input  logic       bus_rst_i,
  input  logic       req_start_i,
  input  logic       req_done_i,
  output logic       core_rst_o,
  output logic       cfg_en_o,
  output logic       attach_o,
  output logic [2:0] state_o,
  output logic       timeout_o
);
  localparam int unsigned LIM_MAX = umax(umax(RECOVER_US, CFG_MAX_US),
                                         umax(ATTACH_MAX_US, RESP_MAX_US));
  localparam int unsigned TW = $clog2(LIM_MAX + 1) + 1;

  logic          rst_hit, pin_hi, tmr_clr, expire;
  logic [TW-1:0] limit;

  rsq_pin_filter #(.RST_MIN_CYC(RST_MIN_CYC)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (ext_rst_ni),
    .hit_o    (rst_hit),
    .pin_hi_o (pin_hi)
  );

  rsq_tick_timer #(.TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .clr_i    (tmr_clr),
    .limit_i  (limit),
    .expire_o (expire)
  );

  rsq_fsm #(
    .TW(TW), .RECOVER_US(RECOVER_US), .CFG_MAX_US(CFG_MAX_US),
    .ATTACH_MAX_US(ATTACH_MAX_US), .RESP_MAX_US(RESP_MAX_US)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_hit_i   (rst_hit),
    .pin_hi_i    (pin_hi),
    .cfg_done_i  (cfg_done_i),
    .bus_rst_i   (bus_rst_i),
    .req_start_i (req_start_i),
    .req_done_i  (req_done_i),
    .expire_i    (expire),
    .tmr_clr_o   (tmr_clr),
    .limit_o     (limit),
    .core_rst_o  (core_rst_o),
    .cfg_en_o    (cfg_en_o),
    .attach_o    (attach_o),
    .state_o     (state_o),
    .timeout_o   (timeout_o)
  );
endmodule

// File: tb/usb_bringup_seq_bench.sv
module usb_bringup_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst_n = 1'b0;
  logic cfg_done = 1'b0, bus_rst = 1'b0, req_start = 1'b0, req_done = 1'b0;
  logic core_rst, cfg_en, attach, timeout;
  logic [2:0] state;
  logic [1:0] tdiv = 2'd0;
  logic tick;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd0);  // one tick every 4 clocks

  usb_bringup_seq #(
    .RST_MIN_CYC(8), .RECOVER_US(20), .CFG_MAX_US(50),
    .ATTACH_MAX_US(40), .RESP_MAX_US(30)
  ) u_usb_bringup_seq (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_rst_n), .tick_i(tick),
    .cfg_done_i(cfg_done), .bus_rst_i(bus_rst), .req_start_i(req_start),
    .req_done_i(req_done), .core_rst_o(core_rst), .cfg_en_o(cfg_en),
    .attach_o(attach), .state_o(state), .timeout_o(timeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wait_n(1); s = 1'b0;
  endtask

  task automatic t_power_on;
    wait_n(3); rst_n = 1'b1; wait_n(4);
    chk("R1 state", state, 0); chk("R1 core_rst", core_rst, 1);
    chk("R1 cfg_en", cfg_en, 0); chk("R1 attach", attach, 0);
    chk("R1 timeout", timeout, 0);
  endtask

  // from reset stage with pin low: release and reach config stage
  task automatic t_to_config(input bit early_done);
    ext_rst_n = 1'b1; wait_n(6);
    chk("R2 recover entry", state, 1); chk("R3 core_rst in recover", core_rst, 1);
    wait_n(34);
    if (early_done) begin
      pulse(cfg_done);
      chk("R3 early done ignored", state, 1);
    end else wait_n(1);
    wait_n(19);
    chk("R3 still recover", state, 1);
    wait_n(50);
    chk("R3 config entry", state, 2); chk("R4 cfg_en", cfg_en, 1);
    chk("R4 core released", core_rst, 0);
  endtask

  task automatic t_pin_reset(input string tag);
    ext_rst_n = 1'b0; wait_n(20);
    chk({tag, " state"}, state, 0); chk({tag, " core_rst"}, core_rst, 1);
    chk({tag, " attach"}, attach, 0); chk({tag, " timeout"}, timeout, 0);
  endtask

  task automatic t_attach_active;
    pulse(cfg_done);
    chk("R5 attach state", state, 3); chk("R5 attach_o", attach, 1);
    chk("R5 cfg_en low", cfg_en, 0);
    wait_n(120);
    chk("R6 still attach", state, 3);
    pulse(bus_rst);
    chk("R6 active", state, 4); chk("R6 attach kept", attach, 1);
  endtask

  task automatic t_glitch(input int exp_state);
    ext_rst_n = 1'b0; wait_n(4); ext_rst_n = 1'b1; wait_n(20);
    chk("R9 glitch state", state, exp_state);
    chk("R9 glitch timeout", timeout, exp_state == 5 ? 1 : 0);
  endtask

  task automatic t_requests;
    pulse(req_start); wait_n(80); pulse(req_done); wait_n(200);
    chk("R7 answered no fault", state, 4); chk("R7 timeout low", timeout, 0);
    pulse(req_start); wait_n(80);
    chk("R7 armed before limit", state, 4);
    wait_n(80);
    chk("R7 response timeout", state, 5); chk("R7 timeout_o", timeout, 1);
    chk("R8 attach dropped", attach, 0); chk("R8 core_rst", core_rst, 1);
  endtask

  task automatic t_fault_sticky;
    pulse(cfg_done); pulse(bus_rst); pulse(req_done); wait_n(100);
    chk("R8 fault held", state, 5); chk("R8 cfg_en low", cfg_en, 0);
  endtask

  task automatic t_cfg_timeout;
    wait_n(120);
    chk("R4 config before limit", state, 2);
    wait_n(100);
    chk("R4 config timeout", state, 5); chk("R4 timeout_o", timeout, 1);
  endtask

  task automatic t_attach_timeout;
    pulse(cfg_done); wait_n(120);
    chk("R6 attach before limit", state, 3);
    wait_n(80);
    chk("R6 attach timeout", state, 5); chk("R6 timeout_o", timeout, 1);
  endtask

  initial begin
    t_power_on();
    t_to_config(1'b1);
    t_attach_active();
    t_glitch(4);
    t_requests();
    t_glitch(5);
    t_fault_sticky();
    t_pin_reset("R2 from fault");
    t_to_config(1'b0);
    t_cfg_timeout();
    t_pin_reset("R2 after cfg fault");
    t_to_config(1'b0);
    t_attach_timeout();
    t_pin_reset("R2 after attach fault");
    t_to_config(1'b0);
    t_glitch(2);
    t_pin_reset("R2 from config");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule